// File: doc/BRIEF.md
# Two-Phase Stepper Motor Sequencer

This block generates the winding drive pattern for a two-phase stepper motor in full-step mode with two windings on at a time. A free-running interval counter, loaded from a programmable step period counted in clock cycles, decides when the motor takes its next step. At each step the block moves one position around a fixed four-position ring of coil patterns, forward or backward according to a direction input. The sequence repeats for as long as the block is enabled, so the motor keeps turning.

The four-bit coil output feeds external power drivers directly. A one-cycle step strobe marks every cycle in which a new pattern first appears. Clearing the enable input freezes both the counter and the coils, and the motor stays at its current position until stepping resumes.

Top module: `stepper_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `coils` is 4'h9 and `step_pulse` is 0.
- R2: `coils` bits 3 down to 0 drive windings A1, A2, B1, B2. In every cycle exactly one A winding (bit 3 or bit 2) and exactly one B winding (bit 1 or bit 0) is on, so exactly two bits are set.
- R3: With `dir_cw` = 0 (anticlockwise), successive steps move through 4'h9, 4'h5, 4'h6, 4'hA and then back to 4'h9.
- R4: With `dir_cw` = 1 (clockwise), successive steps move through 4'hA, 4'h6, 4'h5, 4'h9 and then back to 4'hA. From the reset pattern 4'h9, the first clockwise step gives 4'hA.
- R5: With `step_interval` = N ≥ 1, a step occurs on the Nth enabled clock edge after reset or after the previous step, and on no earlier edge.
- R6: A `step_interval` of 0 behaves as 1: the coils step on every enabled clock edge.
- R7: The direction is sampled at the edge on which a step is taken. Reversing direction continues from the present pattern without returning to the start of the sequence. For example, 4'h6 followed by a clockwise step gives 4'h5.
- R8: While `enable` is 0, the interval count holds, `coils` keeps its value and `step_pulse` is 0. After `enable` returns to 1, the count resumes from where it stopped.
- R9: `step_pulse` is 1 for exactly the one cycle in which a new `coils` value first appears, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run; when low, the counter and the coils hold |
| dir_cw | input | 1 | 1 = clockwise order, 0 = anticlockwise order |
| step_interval | input | 16 | Clock cycles between steps; 0 is treated as 1 |
| coils | output | 4 | Winding drive, {A1, A2, B1, B2} |
| step_pulse | output | 1 | One-cycle strobe marking a new pattern |

## Verification
One register sits between a step decision and the ports. The Nth enabled edge counted from a step updates `coils` and raises `step_pulse` together, and both become visible in the same cycle. The bench drives inputs on falling edges and samples on falling edges. For a period N, it checks that the strobe stays low on the first N−1 samples and that the strobe and the expected pattern appear on the Nth. A pause test stops the count partway through a period and checks that the remaining cycles are still counted after `enable` returns.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    localparam int COIL_W = 4;
    localparam int POS_W  = 2;

    typedef logic [COIL_W-1:0] coil_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef enum logic {
        ROT_ACW = 1'b0,
        ROT_CW  = 1'b1
    } rot_e;

    typedef struct packed {
        logic a1;
        logic a2;
        logic b1;
        logic b2;
    } winding_t;

    localparam coil_t HOME_PATTERN = 4'h9;

    // Ring order of the four full-step positions; anticlockwise walks upward.
    function automatic coil_t ring_pattern(input pos_t p);
        coil_t c;
        case (p)
            2'd0:    c = 4'h9;
            2'd1:    c = 4'h5;
            2'd2:    c = 4'h6;
            default: c = 4'hA;
        endcase
        return c;
    endfunction

    function automatic pos_t ring_move(input pos_t p, input rot_e r);
        return (r == ROT_CW) ? pos_t'(p - 1'b1) : pos_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Zero period is promoted to one, so the last count is period-1 floored at 0.
    always_comb begin
        last = (period == '0) ? '0 : period - 1'b1;
        tick = enable && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else if (enable) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/step_phase.sv
module step_phase
    import stepseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  rot_e rot,
    output pos_t pos,
    output logic strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= advance;
            if (advance) begin
                pos <= ring_move(pos, rot);
            end
        end
    end
endmodule

// File: rtl/coil_decode.sv
module coil_decode
    import stepseq_pkg::*;
(
    input  pos_t     pos,
    output winding_t drive
);
    coil_t raw;

    always_comb begin
        raw   = ring_pattern(pos);
        drive = winding_t'(raw);
    end
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
    import stepseq_pkg::*;
#(
    parameter int INTERVAL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  dir_cw,
    input  logic [INTERVAL_W-1:0] step_interval,
    output logic [3:0]            coils,
    output logic                  step_pulse
);
    logic     tick;
    pos_t     pos;
    rot_e     rot;
    winding_t drive;

    assign rot = dir_cw ? ROT_CW : ROT_ACW;

    step_timer #(.CNT_W(INTERVAL_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .period (step_interval),
        .tick   (tick)
    );

    step_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .advance (tick),
        .rot     (rot),
        .pos     (pos),
        .strobe  (step_pulse)
    );

    coil_decode u_dec (
        .pos   (pos),
        .drive (drive)
    );

    assign coils = {drive.a1, drive.a2, drive.b1, drive.b2};
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk #(
    parameter int INTERVAL_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  enable,
    input logic                  dir_cw,
    input logic [INTERVAL_W-1:0] step_interval,
    input logic [3:0]            coils,
    input logic                  step_pulse
);
    logic rst_seen = 1'b0;

    always_ff @(posedge clk) rst_seen <= rst;

    function automatic logic [3:0] acw_next(input logic [3:0] c);
        case (c)
            4'h9:    return 4'h5;
            4'h5:    return 4'h6;
            4'h6:    return 4'hA;
            default: return 4'h9;
        endcase
    endfunction

    function automatic logic [3:0] cw_next(input logic [3:0] c);
        case (c)
            4'hA:    return 4'h6;
            4'h6:    return 4'h5;
            4'h5:    return 4'h9;
            default: return 4'hA;
        endcase
    endfunction

    // R1
    always @(negedge clk) begin
        if (rst_seen) begin
            reset_state_chk: assert (coils == 4'h9 && !step_pulse);
        end
    end

    // R2
    two_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(coils) == 2) && (coils[3] ^ coils[2]) && (coils[1] ^ coils[0]));

    // R3
    acw_order_chk: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && !$past(dir_cw)) |-> (coils == acw_next($past(coils))));

    // R4
    cw_order_chk: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && $past(dir_cw)) |-> (coils == cw_next($past(coils))));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!step_pulse && $stable(coils)));

    // R9
    pulse_marks_change_chk: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> (coils != $past(coils)));

    // R9
    quiet_means_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !step_pulse |-> $stable(coils));

    // R6
    zero_period_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && step_interval == '0) |=> step_pulse);
endmodule

bind stepper_seq stepper_seq_chk #(.INTERVAL_W(INTERVAL_W)) u_chk (.*);

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        dir_cw = 1'b0;
    logic [15:0] step_interval = 16'd1;
    logic [3:0]  coils;
    logic        step_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepper_seq u_dut (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .dir_cw        (dir_cw),
        .step_interval (step_interval),
        .coils         (coils),
        .step_pulse    (step_pulse)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Run n enabled cycles from a zero count; only the nth may show the step.
    task automatic expect_step(input int n, input logic [3:0] exp, input string req);
        logic early = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i < n && step_pulse) early = 1'b1;
        end
        check(!early, {req, " no early step"}, int'(early), 0);
        check(step_pulse && coils == exp, req, int'({step_pulse, coils}), int'({1'b1, exp}));
        // R2 adjacency: one A winding and one B winding on
        check((coils[3] ^ coils[2]) && (coils[1] ^ coils[0]), "R2 adjacency", int'(coils), int'(exp));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(coils == 4'h9 && !step_pulse, "R1 reset state", int'({step_pulse, coils}), 9);
        rst = 1'b0;
        @(negedge clk);
        check(coils == 4'h9 && !step_pulse, "R1 after release", int'({step_pulse, coils}), 9);
    endtask

    task automatic t_acw();
        dir_cw = 1'b0; step_interval = 16'd3; enable = 1'b1;
        expect_step(3, 4'h5, "R3 acw 9->5");
        @(negedge clk); // R9: strobe lasts one cycle
        check(!step_pulse, "R9 pulse width", int'(step_pulse), 0);
        expect_step(2, 4'h6, "R3 acw 5->6 R5");
        expect_step(3, 4'hA, "R3 acw 6->A");
        expect_step(3, 4'h9, "R3 acw wrap A->9");
    endtask

    task automatic t_cw();
        dir_cw = 1'b1; step_interval = 16'd2;
        expect_step(2, 4'hA, "R4 cw 9->A");
        expect_step(2, 4'h6, "R4 cw A->6");
        expect_step(2, 4'h5, "R4 cw 6->5");
        expect_step(2, 4'h9, "R4 cw 5->9");
        expect_step(2, 4'hA, "R4 cw wrap 9->A");
    endtask

    task automatic t_long();
        dir_cw = 1'b0; step_interval = 16'd7;
        expect_step(7, 4'h9, "R5 period 7");
    endtask

    task automatic t_zero();
        step_interval = 16'd0;
        expect_step(1, 4'h5, "R6 zero period step 1");
        expect_step(1, 4'h6, "R6 zero period step 2");
    endtask

    task automatic t_reverse();
        dir_cw = 1'b1; step_interval = 16'd2;
        expect_step(2, 4'h5, "R7 reverse from 6");
        expect_step(2, 4'h9, "R7 continue cw");
    endtask

    task automatic t_hold();
        logic moved = 1'b0;
        dir_cw = 1'b0; step_interval = 16'd4;
        repeat (2) @(negedge clk);
        check(!step_pulse && coils == 4'h9, "R8 partial count", int'({step_pulse, coils}), 9);
        enable = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (step_pulse || coils != 4'h9) moved = 1'b1;
        end
        check(!moved, "R8 hold while disabled", int'(moved), 0);
        enable = 1'b1;
        expect_step(2, 4'h5, "R8 resume count");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_acw();
        t_cw();
        t_long();
        t_zero();
        t_reverse();
        t_hold();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule